// File: doc/BRIEF.md
# Counter-Rotating Dual Ring Interconnect

This block is the on-chip fabric that joins eight cache-slice stops and two gateway stops into a single loop of ten positions. The loop is built twice: one copy moves packets clockwise and the other moves them counter-clockwise, one stop per clock. A packet is a stop identifier plus a 256-bit (32-byte) payload. A slice that hands a packet to its stop has that packet placed on whichever ring reaches the destination in fewer hops. Every stop takes packets addressed to itself off the ring through a local valid/ready eject port.

Two of the ten positions connect the fabric to an external switch. One serves only the clockwise ring and the other serves only the counter-clockwise ring. Each of these gateways has an ingress port, through which the switch injects onto that gateway's ring, and an egress port, which delivers the packets on that ring that are addressed to the gateway. Traffic already on a ring always has precedence over new traffic at a stop. A packet whose destination is not ready stays on the ring and comes back one full loop later.

Top module: `ring_fabric`

## Requirements
- R1: After reset, both rings are empty. In the first cycle after reset deasserts, every inject ready (slice and gateway ingress) is 0, and no eject or egress valid is asserted.
- R2: Stop numbering and movement are fixed. Stops 0..7 are slices, stop 8 is the clockwise gateway and stop 9 is the counter-clockwise gateway. Clockwise hops go from stop i to (i+1) mod 10, counter-clockwise hops from i to (i+9) mod 10. A packet accepted at its source in cycle t shows eject valid at its destination in cycle t+k, where k is the hop count on its ring, and not earlier.
- R3: A slice chooses its direction from the 4-bit destination field. For slice destinations it takes the ring with fewer hops and breaks a tie toward clockwise. Destination 8 always goes clockwise and destination 9 always goes counter-clockwise. A destination equal to the source travels clockwise for a full loop of 10 hops.
- R4: The ingress port of gateway 8 injects only onto the clockwise ring, and the ingress port of gateway 9 injects only onto the counter-clockwise ring. Gateway ingress destinations are limited to slices 0..7.
- R5: An injection at a stop is refused (ready 0) when that stop's slot on the chosen ring holds a packet that is not ejected there in the same cycle.
- R6: A packet is ejected in the cycle it reaches its destination if that stop's eject ready is high. Otherwise it keeps circulating and is offered again 10 cycles later.
- R7: When packets on both rings reach the same slice in the same cycle, the clockwise packet is presented and taken. The counter-clockwise packet keeps circulating.
- R8: A slot freed by an ejection in a cycle is available for an injection at the same stop in that same cycle.
- R9: The 256-bit payload reaches the eject port unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sl_inj_valid | input | 8 | Per-slice inject request |
| sl_inj_ready | output | 8 | Per-slice inject accepted |
| sl_inj_dest | input | 32 | Per-slice destination, 4 bits per slice |
| sl_inj_data | input | 2048 | Per-slice payload, 256 bits per slice |
| sl_ej_valid | output | 8 | Per-slice packet arriving for the slice |
| sl_ej_ready | input | 8 | Per-slice willingness to take an arrival |
| sl_ej_data | output | 2048 | Per-slice arriving payload |
| gcw_in_valid | input | 1 | Clockwise gateway ingress request |
| gcw_in_ready | output | 1 | Clockwise gateway ingress accepted |
| gcw_in_dest | input | 4 | Clockwise gateway ingress destination |
| gcw_in_data | input | 256 | Clockwise gateway ingress payload |
| gcw_out_valid | output | 1 | Clockwise gateway egress valid |
| gcw_out_ready | input | 1 | Clockwise gateway egress ready |
| gcw_out_data | output | 256 | Clockwise gateway egress payload |
| gccw_in_valid | input | 1 | Counter-clockwise gateway ingress request |
| gccw_in_ready | output | 1 | Counter-clockwise gateway ingress accepted |
| gccw_in_dest | input | 4 | Counter-clockwise gateway ingress destination |
| gccw_in_data | input | 256 | Counter-clockwise gateway ingress payload |
| gccw_out_valid | output | 1 | Counter-clockwise gateway egress valid |
| gccw_out_ready | input | 1 | Counter-clockwise gateway egress ready |
| gccw_out_data | output | 256 | Counter-clockwise gateway egress payload |

## Verification
The bench builds the block with its default parameters: eight slices, a 256-bit payload and therefore a ten-position loop. With that size, half-loop ties (five hops each way) occur between real slice pairs, so the tie-break can be observed through the blocking it causes on the next stop. A refused eject or the loser of a double arrival comes back after only ten cycles. Directed cases pin exact arrival cycles, and a long random phase with random eject back-pressure is compared against a behavioural model on every clock.

// File: rtl/ring_pkg.sv
package ring_pkg;

    parameter int unsigned SLICES = 8;
    parameter int unsigned DATA_W = 256;

    localparam int unsigned STOPS  = SLICES + 2;
    localparam int unsigned ID_W   = $clog2(STOPS);
    localparam int unsigned GW_CW  = SLICES;
    localparam int unsigned GW_CCW = SLICES + 1;

    typedef logic [ID_W-1:0] stop_id_t;

    typedef struct packed {
        stop_id_t          dest;
        logic [DATA_W-1:0] data;
    } pkt_t;

    typedef struct packed {
        logic vld;
        pkt_t pkt;
    } slot_t;

    typedef enum logic {
        DIR_CW  = 1'b0,
        DIR_CCW = 1'b1
    } dir_t;

    // hop count from one stop to another travelling in direction d
    function automatic int unsigned hops(input stop_id_t from, input stop_id_t to, input dir_t d);
        int unsigned f;
        int unsigned t;
        f = 32'(from);
        t = 32'(to);
        if (d == DIR_CW) return (t + STOPS - f) % STOPS;
        return (f + STOPS - t) % STOPS;
    endfunction

    // direction for a packet leaving a slice stop
    function automatic dir_t pick_dir(input stop_id_t src, input stop_id_t dst);
        int unsigned n_cw;
        int unsigned n_ccw;
        if (32'(dst) == GW_CW)  return DIR_CW;
        if (32'(dst) == GW_CCW) return DIR_CCW;
        n_cw  = hops(src, dst, DIR_CW);
        n_ccw = hops(src, dst, DIR_CCW);
        if (n_ccw < n_cw) return DIR_CCW;
        return DIR_CW;
    endfunction

endpackage

// File: rtl/ring_lane.sv
module ring_lane
    import ring_pkg::*;
#(
    parameter dir_t DIR = DIR_CW
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  inj_fire [STOPS],
    input  pkt_t  inj_pkt  [STOPS],
    input  logic  take     [STOPS],
    output slot_t at_stop  [STOPS],
    output logic  free     [STOPS]
);

    slot_t cur [STOPS];

    for (genvar i = 0; i < STOPS; i++) begin : g_hop
        localparam int unsigned UP = (DIR == DIR_CW) ? (i + STOPS - 1) % STOPS : (i + 1) % STOPS;
        localparam int unsigned DN = (DIR == DIR_CW) ? (i + 1) % STOPS : (i + STOPS - 1) % STOPS;

        slot_t q;

        always_ff @(posedge clk) begin
            if (rst) begin
                q <= '0;
            end else if (cur[UP].vld && !take[UP]) begin
                q <= cur[UP];
            end else if (inj_fire[UP]) begin
                q <= '{vld: 1'b1, pkt: inj_pkt[UP]};
            end else begin
                q <= '0;
            end
        end

        assign cur[i]     = q;
        assign at_stop[i] = q;
        assign free[i]    = !q.vld || take[i];

        // R2
        hop_forward_chk: assert property (@(posedge clk) disable iff (rst)
            (cur[i].vld && !take[i]) |=> (cur[DN].vld && cur[DN].pkt == $past(cur[i].pkt)));

        // R5
        inject_into_free_chk: assert property (@(posedge clk) disable iff (rst)
            inj_fire[i] |-> (!cur[i].vld || take[i]));

        // R6
        take_at_dest_chk: assert property (@(posedge clk) disable iff (rst)
            take[i] |-> (cur[i].vld && 32'(cur[i].pkt.dest) == i));
    end

endmodule

// File: rtl/ring_stop.sv
module ring_stop
    import ring_pkg::*;
#(
    parameter int unsigned ID = 0
) (
    input  logic              live,
    input  logic              inj_valid,
    input  pkt_t              inj_pkt,
    output logic              inj_ready,
    output logic              ej_valid,
    input  logic              ej_ready,
    output logic [DATA_W-1:0] ej_data,
    input  slot_t             cw_slot,
    input  slot_t             ccw_slot,
    input  logic              cw_free,
    input  logic              ccw_free,
    output logic              cw_take,
    output logic              ccw_take,
    output logic              cw_fire,
    output logic              ccw_fire
);

    localparam bit       ON_CW  = (ID != GW_CCW);
    localparam bit       ON_CCW = (ID != GW_CW);
    localparam stop_id_t ME     = stop_id_t'(ID);

    dir_t want;
    logic cw_hit;
    logic ccw_hit;

    always_comb begin
        if (ID == GW_CW)       want = DIR_CW;
        else if (ID == GW_CCW) want = DIR_CCW;
        else                   want = pick_dir(ME, inj_pkt.dest);

        cw_hit   = ON_CW  && cw_slot.vld  && (cw_slot.pkt.dest  == ME);
        ccw_hit  = ON_CCW && ccw_slot.vld && (ccw_slot.pkt.dest == ME);

        ej_valid = cw_hit || ccw_hit;
        ej_data  = cw_hit ? cw_slot.pkt.data : ccw_slot.pkt.data;
        cw_take  = cw_hit && ej_ready;
        ccw_take = ccw_hit && !cw_hit && ej_ready;

        inj_ready = live && ((want == DIR_CW) ? cw_free : ccw_free);
        cw_fire   = inj_valid && inj_ready && (want == DIR_CW);
        ccw_fire  = inj_valid && inj_ready && (want == DIR_CCW);
    end

endmodule

// File: rtl/ring_fabric.sv
module ring_fabric
    import ring_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic [SLICES-1:0]        sl_inj_valid,
    output logic [SLICES-1:0]        sl_inj_ready,
    input  logic [SLICES*ID_W-1:0]   sl_inj_dest,
    input  logic [SLICES*DATA_W-1:0] sl_inj_data,
    output logic [SLICES-1:0]        sl_ej_valid,
    input  logic [SLICES-1:0]        sl_ej_ready,
    output logic [SLICES*DATA_W-1:0] sl_ej_data,
    input  logic                     gcw_in_valid,
    output logic                     gcw_in_ready,
    input  logic [ID_W-1:0]          gcw_in_dest,
    input  logic [DATA_W-1:0]        gcw_in_data,
    output logic                     gcw_out_valid,
    input  logic                     gcw_out_ready,
    output logic [DATA_W-1:0]        gcw_out_data,
    input  logic                     gccw_in_valid,
    output logic                     gccw_in_ready,
    input  logic [ID_W-1:0]          gccw_in_dest,
    input  logic [DATA_W-1:0]        gccw_in_data,
    output logic                     gccw_out_valid,
    input  logic                     gccw_out_ready,
    output logic [DATA_W-1:0]        gccw_out_data
);

    logic live;

    always_ff @(posedge clk) begin
        if (rst) live <= 1'b0;
        else     live <= 1'b1;
    end

    logic              st_inj_v  [STOPS];
    pkt_t              st_pkt    [STOPS];
    logic              st_inj_r  [STOPS];
    logic              st_ej_v   [STOPS];
    logic              st_ej_r   [STOPS];
    logic [DATA_W-1:0] st_ej_d   [STOPS];

    logic  cw_fire  [STOPS];
    logic  ccw_fire [STOPS];
    logic  cw_take  [STOPS];
    logic  ccw_take [STOPS];
    slot_t cw_at    [STOPS];
    slot_t ccw_at   [STOPS];
    logic  cw_free  [STOPS];
    logic  ccw_free [STOPS];

    for (genvar s = 0; s < STOPS; s++) begin : g_stop
        if (s < SLICES) begin : g_slice
            assign st_inj_v[s]              = sl_inj_valid[s];
            assign st_pkt[s]                = '{dest: sl_inj_dest[s*ID_W +: ID_W],
                                                data: sl_inj_data[s*DATA_W +: DATA_W]};
            assign sl_inj_ready[s]          = st_inj_r[s];
            assign sl_ej_valid[s]           = st_ej_v[s];
            assign st_ej_r[s]               = sl_ej_ready[s];
            assign sl_ej_data[s*DATA_W +: DATA_W] = st_ej_d[s];
        end else if (s == GW_CW) begin : g_gw_cw
            assign st_inj_v[s]   = gcw_in_valid;
            assign st_pkt[s]     = '{dest: gcw_in_dest, data: gcw_in_data};
            assign gcw_in_ready  = st_inj_r[s];
            assign gcw_out_valid = st_ej_v[s];
            assign st_ej_r[s]    = gcw_out_ready;
            assign gcw_out_data  = st_ej_d[s];
        end else begin : g_gw_ccw
            assign st_inj_v[s]    = gccw_in_valid;
            assign st_pkt[s]      = '{dest: gccw_in_dest, data: gccw_in_data};
            assign gccw_in_ready  = st_inj_r[s];
            assign gccw_out_valid = st_ej_v[s];
            assign st_ej_r[s]     = gccw_out_ready;
            assign gccw_out_data  = st_ej_d[s];
        end

        ring_stop #(.ID(s)) u_stop (
            .live      (live),
            .inj_valid (st_inj_v[s]),
            .inj_pkt   (st_pkt[s]),
            .inj_ready (st_inj_r[s]),
            .ej_valid  (st_ej_v[s]),
            .ej_ready  (st_ej_r[s]),
            .ej_data   (st_ej_d[s]),
            .cw_slot   (cw_at[s]),
            .ccw_slot  (ccw_at[s]),
            .cw_free   (cw_free[s]),
            .ccw_free  (ccw_free[s]),
            .cw_take   (cw_take[s]),
            .ccw_take  (ccw_take[s]),
            .cw_fire   (cw_fire[s]),
            .ccw_fire  (ccw_fire[s])
        );
    end

    ring_lane #(.DIR(DIR_CW)) u_cw (
        .clk      (clk),
        .rst      (rst),
        .inj_fire (cw_fire),
        .inj_pkt  (st_pkt),
        .take     (cw_take),
        .at_stop  (cw_at),
        .free     (cw_free)
    );

    ring_lane #(.DIR(DIR_CCW)) u_ccw (
        .clk      (clk),
        .rst      (rst),
        .inj_fire (ccw_fire),
        .inj_pkt  (st_pkt),
        .take     (ccw_take),
        .at_stop  (ccw_at),
        .free     (ccw_free)
    );

    // R1
    empty_after_reset_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (sl_ej_valid == '0 && !gcw_out_valid && !gccw_out_valid &&
                        sl_inj_ready == '0 && !gcw_in_ready && !gccw_in_ready));

endmodule

// File: tb/ring_fabric_test.sv
module ring_fabric_test;
    import ring_pkg::*;

    logic clk = 1'b0;
    always #5 clk = ~clk;
    logic rst;

    logic [SLICES-1:0]        sl_inj_valid, sl_inj_ready, sl_ej_valid, sl_ej_ready;
    logic [SLICES*ID_W-1:0]   sl_inj_dest;
    logic [SLICES*DATA_W-1:0] sl_inj_data, sl_ej_data;
    logic                     gcw_in_valid, gcw_in_ready, gcw_out_valid, gcw_out_ready;
    logic [ID_W-1:0]          gcw_in_dest, gccw_in_dest;
    logic [DATA_W-1:0]        gcw_in_data, gcw_out_data, gccw_in_data, gccw_out_data;
    logic                     gccw_in_valid, gccw_in_ready, gccw_out_valid, gccw_out_ready;

    ring_fabric uut (.*);

    int total = 0;
    int bad   = 0;

    // bench-side stimulus per stop
    logic b_v [STOPS];
    int   b_d [STOPS];
    int   b_t [STOPS];
    logic b_r [STOPS];

    // reference model state
    logic m_live;
    logic mcv [STOPS];  int mcd [STOPS];  int mct [STOPS];
    logic mqv [STOPS];  int mqd [STOPS];  int mqt [STOPS];
    logic ncv [STOPS];  int ncd [STOPS];  int nct [STOPS];
    logic nqv [STOPS];  int nqd [STOPS];  int nqt [STOPS];
    logic e_rdy [STOPS];
    logic e_ejv [STOPS];
    int   e_tag [STOPS];

    function automatic logic [DATA_W-1:0] mk(input int t);
        return {(DATA_W/32){32'(t)}};
    endfunction

    always_comb begin
        for (int s = 0; s < SLICES; s++) begin
            sl_inj_valid[s] = b_v[s];
            sl_inj_dest[s*ID_W +: ID_W] = stop_id_t'(b_d[s]);
            sl_inj_data[s*DATA_W +: DATA_W] = mk(b_t[s]);
            sl_ej_ready[s] = b_r[s];
        end
        gcw_in_valid   = b_v[GW_CW];
        gcw_in_dest    = stop_id_t'(b_d[GW_CW]);
        gcw_in_data    = mk(b_t[GW_CW]);
        gcw_out_ready  = b_r[GW_CW];
        gccw_in_valid  = b_v[GW_CCW];
        gccw_in_dest   = stop_id_t'(b_d[GW_CCW]);
        gccw_in_data   = mk(b_t[GW_CCW]);
        gccw_out_ready = b_r[GW_CCW];
    end

    function automatic logic dut_rdy(input int i);
        if (i < SLICES) return sl_inj_ready[i];
        if (i == GW_CW) return gcw_in_ready;
        return gccw_in_ready;
    endfunction

    function automatic logic dut_ejv(input int i);
        if (i < SLICES) return sl_ej_valid[i];
        if (i == GW_CW) return gcw_out_valid;
        return gccw_out_valid;
    endfunction

    function automatic logic [DATA_W-1:0] dut_ejd(input int i);
        if (i < SLICES) return sl_ej_data[i*DATA_W +: DATA_W];
        if (i == GW_CW) return gcw_out_data;
        return gccw_out_data;
    endfunction

    // direction choice from the requirements: 1 = clockwise
    function automatic logic want_cw(input int i, input int d);
        int a;
        int b;
        if (i == GW_CW)  return 1'b1;
        if (i == GW_CCW) return 1'b0;
        if (d == GW_CW)  return 1'b1;
        if (d == GW_CCW) return 1'b0;
        a = (d - i + STOPS) % STOPS;
        b = (i - d + STOPS) % STOPS;
        return !(b < a);
    endfunction

    task automatic chk(input logic ok, input string what, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d t=%0t", what, act, exp, $time);
        end
    endtask

    task automatic clr();
        for (int i = 0; i < STOPS; i++) begin
            b_v[i] = 1'b0; b_d[i] = 0; b_t[i] = 0; b_r[i] = 1'b1;
        end
    endtask

    task automatic model_reset();
        m_live = 1'b0;
        for (int i = 0; i < STOPS; i++) begin
            mcv[i] = 1'b0; mcd[i] = 0; mct[i] = 0;
            mqv[i] = 1'b0; mqd[i] = 0; mqt[i] = 0;
        end
    endtask

    // mid-cycle: evaluate model against DUT and prepare next state
    task automatic eval();
        #4;
        for (int i = 0; i < STOPS; i++) begin
            ncv[(i+1)%STOPS] = 1'b0;
            nqv[(i+STOPS-1)%STOPS] = 1'b0;
        end
        for (int i = 0; i < STOPS; i++) begin
            logic hc, hq, tc, tq, fc, fq, cwd, fire;
            int dn_c, dn_q;
            dn_c = (i + 1) % STOPS;
            dn_q = (i + STOPS - 1) % STOPS;
            hc   = (i != GW_CCW) && mcv[i] && (mcd[i] == i);
            hq   = (i != GW_CW)  && mqv[i] && (mqd[i] == i);
            tc   = hc && b_r[i];
            tq   = hq && !hc && b_r[i];
            fc   = !mcv[i] || tc;
            fq   = !mqv[i] || tq;
            cwd  = want_cw(i, b_d[i]);
            e_rdy[i] = m_live && (cwd ? fc : fq);
            e_ejv[i] = hc || hq;
            e_tag[i] = hc ? mct[i] : mqt[i];
            fire = b_v[i] && e_rdy[i];
            if (mcv[i] && !tc) begin
                ncv[dn_c] = 1'b1; ncd[dn_c] = mcd[i]; nct[dn_c] = mct[i];
            end else if (fire && cwd) begin
                ncv[dn_c] = 1'b1; ncd[dn_c] = b_d[i]; nct[dn_c] = b_t[i];
            end
            if (mqv[i] && !tq) begin
                nqv[dn_q] = 1'b1; nqd[dn_q] = mqd[i]; nqt[dn_q] = mqt[i];
            end else if (fire && !cwd) begin
                nqv[dn_q] = 1'b1; nqd[dn_q] = b_d[i]; nqt[dn_q] = b_t[i];
            end
        end
        for (int i = 0; i < STOPS; i++) begin
            chk(dut_rdy(i) === e_rdy[i], $sformatf("R5 inject ready stop %0d", i),
                longint'(dut_rdy(i)), longint'(e_rdy[i]));
            chk(dut_ejv(i) === e_ejv[i], $sformatf("R6 eject valid stop %0d", i),
                longint'(dut_ejv(i)), longint'(e_ejv[i]));
            if (e_ejv[i])
                chk(dut_ejd(i) === mk(e_tag[i]), $sformatf("R9 payload stop %0d", i),
                    longint'(dut_ejd(i)[31:0]), longint'(e_tag[i]));
        end
    endtask

    task automatic adv();
        @(posedge clk);
        #1;
        for (int i = 0; i < STOPS; i++) begin
            mcv[i] = ncv[i]; mcd[i] = ncd[i]; mct[i] = nct[i];
            mqv[i] = nqv[i]; mqd[i] = nqd[i]; mqt[i] = nqt[i];
        end
        m_live = 1'b1;
    endtask

    task automatic tick();
        eval();
        adv();
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) tick();
    endtask

    // inject one packet and watch its exact arrival cycle
    task automatic send_watch(input int src, input int dst, input int tag, input int nhop, input string req);
        b_v[src] = 1'b1; b_d[src] = dst; b_t[src] = tag;
        eval();
        chk(dut_rdy(src) === 1'b1, {req, " accept"}, longint'(dut_rdy(src)), 1);
        adv();
        clr();
        for (int k = 1; k < nhop; k++) begin
            eval();
            chk(dut_ejv(dst) === 1'b0, {req, " early arrival"}, longint'(dut_ejv(dst)), 0);
            adv();
        end
        eval();
        chk(dut_ejv(dst) === 1'b1 && dut_ejd(dst) === mk(tag), {req, " arrival"},
            longint'(dut_ejd(dst)[31:0]), longint'(tag));
        adv();
        idle(12);
    endtask

    initial begin
        #(100000 * 10);
        bad++;
        $display("FAIL R2 watchdog act=running exp=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int tag;
        clr();
        model_reset();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;

        // R1: first cycle after reset, requests present but all refused
        for (int i = 0; i < STOPS; i++) begin
            b_v[i] = 1'b1; b_d[i] = (i + 1) % SLICES; b_t[i] = 50 + i;
        end
        eval();
        chk(sl_inj_ready == '0 && !gcw_in_ready && !gccw_in_ready, "R1 ready after reset",
            longint'(sl_inj_ready), 0);
        chk(sl_ej_valid == '0 && !gcw_out_valid && !gccw_out_valid, "R1 eject after reset",
            longint'(sl_ej_valid), 0);
        adv();
        clr();
        idle(2);

        // R2 / R3 direction and hop timing
        send_watch(0, 3, 101, 3, "R2 0->3 cw");
        send_watch(3, 1, 102, 2, "R3 3->1 ccw");
        send_watch(7, 1, 103, 4, "R3 7->1 cw via gateways");
        send_watch(6, 1, 104, 5, "R3 6->1 tie");
        send_watch(2, 2, 105, 10, "R3 self full loop");
        send_watch(7, 9, 106, 8, "R3 dest 9 forced ccw");
        send_watch(1, 8, 107, 7, "R3 dest 8 forced cw");
        // R4 gateway ingress rings
        send_watch(8, 3, 108, 5, "R4 gw8 cw");
        send_watch(9, 6, 109, 3, "R4 gw9 ccw");
        send_watch(9, 0, 110, 9, "R4 gw9 long way");

        // R3 tie-break observed through blocking at stop 1 clockwise
        b_v[0] = 1'b1; b_d[0] = 5; b_t[0] = 120;
        tick();
        clr();
        b_v[1] = 1'b1; b_d[1] = 2; b_t[1] = 121;
        eval();
        chk(sl_inj_ready[1] === 1'b0, "R3 tie went clockwise", longint'(sl_inj_ready[1]), 0);
        adv();
        clr();
        idle(15);

        // R6 refused eject recirculates
        b_v[0] = 1'b1; b_d[0] = 2; b_t[0] = 130;
        tick();
        clr();
        tick();
        b_r[2] = 1'b0;
        eval();
        chk(sl_ej_valid[2] === 1'b1, "R6 offered while not ready", longint'(sl_ej_valid[2]), 1);
        adv();
        clr();
        for (int k = 0; k < 9; k++) begin
            eval();
            chk(sl_ej_valid[2] === 1'b0, "R6 gone during loop", longint'(sl_ej_valid[2]), 0);
            adv();
        end
        eval();
        chk(sl_ej_valid[2] === 1'b1 && sl_ej_data[2*DATA_W +: 32] === 32'd130, "R6 returns after loop",
            longint'(sl_ej_data[2*DATA_W +: 32]), 130);
        adv();
        idle(12);

        // R7 both rings arrive at slice 4 together
        b_v[2] = 1'b1; b_d[2] = 4; b_t[2] = 201;
        b_v[6] = 1'b1; b_d[6] = 4; b_t[6] = 202;
        tick();
        clr();
        tick();
        eval();
        chk(sl_ej_valid[4] === 1'b1 && sl_ej_data[4*DATA_W +: 32] === 32'd201, "R7 clockwise wins",
            longint'(sl_ej_data[4*DATA_W +: 32]), 201);
        adv();
        for (int k = 0; k < 9; k++) begin
            eval();
            chk(sl_ej_valid[4] === 1'b0, "R7 loser circulating", longint'(sl_ej_valid[4]), 0);
            adv();
        end
        eval();
        chk(sl_ej_valid[4] === 1'b1 && sl_ej_data[4*DATA_W +: 32] === 32'd202, "R7 loser delivered",
            longint'(sl_ej_data[4*DATA_W +: 32]), 202);
        adv();
        idle(12);

        // R8 ejected slot reused in same cycle
        b_v[0] = 1'b1; b_d[0] = 3; b_t[0] = 301;
        tick();
        clr();
        idle(2);
        b_v[3] = 1'b1; b_d[3] = 5; b_t[3] = 302;
        eval();
        chk(sl_inj_ready[3] === 1'b1, "R8 freed slot reusable", longint'(sl_inj_ready[3]), 1);
        adv();
        clr();
        idle(12);

        // R5 occupied slot blocks injection when eject refused
        b_v[0] = 1'b1; b_d[0] = 3; b_t[0] = 311;
        tick();
        clr();
        idle(2);
        b_v[3] = 1'b1; b_d[3] = 5; b_t[3] = 312; b_r[3] = 1'b0;
        eval();
        chk(sl_inj_ready[3] === 1'b0, "R5 ring traffic has priority", longint'(sl_inj_ready[3]), 0);
        adv();
        clr();
        idle(15);

        // random traffic with back-pressure, compared every cycle
        tag = 1000;
        for (int c = 0; c < 3000; c++) begin
            for (int i = 0; i < STOPS; i++) begin
                b_v[i] = ($urandom_range(0, 99) < 35);
                b_d[i] = (i < SLICES) ? int'($urandom_range(0, STOPS - 1)) : int'($urandom_range(0, SLICES - 1));
                b_t[i] = tag;
                tag++;
                b_r[i] = ($urandom_range(0, 99) < 70);
            end
            tick();
        end
        clr();
        idle(40);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule